// File: doc/BRIEF.md
# Strobe-Clocked Fall-Through FIFO

This block is a small first-in first-out store of 16 words of 4 bits. Its producer and consumer do not give it per-cycle request signals. Each side moves a strobe line instead. A word is taken in when the load strobe goes from high to low, and the load strobe rests low between transfers. A word is given up when the unload strobe goes from low to high, and the unload strobe rests high. One system clock samples both strobes through a two-flop synchronizer. An edge detector on the synchronized level turns each transition into a one-cycle event.

Storage is addressed by two one-hot ring pointers, so no address decoder is needed. The output always presents the oldest stored word, which means the first word falls through without any unload action. Two ready flags report the state to the two sides. Input-ready means a load would be accepted and the load strobe is at rest. Output-ready means the presented word is valid and the unload strobe is at rest. Each flag has its own enable input.

An active-low clear returns the block to its empty state. The output enable only gates the drive enables that go to the pads; it does not touch the flags.

Top module: `strobe_fifo`

## Requirements
- R1: The store holds up to DEPTH (16) words of WIDTH (4) bits, and words leave in the same order they arrived.
- R2: A high-to-low transition on `ld_stb` writes `din`. The write is visible at the outputs at the third rising clock edge after the strobe changes.
- R3: A low-to-high transition on `ul_stb` discards the oldest word. The next word appears on `dout` at the third rising clock edge after the strobe changes.
- R4: When 16 more words have been loaded than unloaded, `in_rdy` is low and further load transitions leave the contents and pointers unchanged.
- R5: An unload transition while the store is empty has no effect.
- R6: `in_rdy` is 1 only when the store is not full, the synchronized `ld_stb` is low, and `in_rdy_en` is 1.
- R7: `out_rdy` is 1 only when the store is not empty, the synchronized `ul_stb` is high, and `out_rdy_en` is 1.
- R8: While `clr_n` is low, both pointers return to slot 0 and the count returns to zero. After release, with idle strobes and both enables set, `in_rdy` is 1 and `out_rdy` is 0.
- R9: The write and read pointers are one-hot rings that wrap from the last slot back to the first after DEPTH advances.
- R10: With `oe` at 0, every bit of `dout_oe` is 0. With `oe` at 1, every bit is 1. `oe` never changes `in_rdy` or `out_rdy`, and `dout` carries stored data without inversion.
- R11: `dout` always shows the word at the read pointer, so the first loaded word appears without an unload transition.
- R12: A load and an unload detected in the same clock cycle, with the store neither empty nor full, leave the count unchanged and advance both pointers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples both strobes |
| clr_n | input | 1 | Active-low asynchronous clear |
| ld_stb | input | 1 | Load strobe; writes on its falling transition |
| ul_stb | input | 1 | Unload strobe; reads on its rising transition |
| in_rdy_en | input | 1 | Enable for the input-ready flag |
| out_rdy_en | input | 1 | Enable for the output-ready flag |
| oe | input | 1 | Output enable for the data drivers |
| din | input | WIDTH | Word to be written |
| dout | output | WIDTH | Oldest stored word |
| dout_oe | output | WIDTH | Per-bit drive enable for the data pads |
| in_rdy | output | 1 | Input-ready flag |
| out_rdy | output | 1 | Output-ready flag |

## Verification
Each strobe passes through three registers before it takes effect: two synchronizer stages and the stage that holds the previous level. Pointer, count and flag updates therefore all land on the third rising edge after a strobe pin changes. The bench drives all inputs on falling edges and samples on falling edges. For the latency checks it samples exactly after the second edge, where the old value is expected, and after the third edge, where the new value is expected. Every other transfer waits four falling edges before the bench looks at the outputs. The enable and output-enable inputs act combinationally, so they are checked on the next falling edge.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
    // Which strobe transition produces the one-cycle event.
    typedef enum logic {
        EDGE_FALL = 1'b0,
        EDGE_RISE = 1'b1
    } edge_sel_e;
endpackage

// File: rtl/strobe_sync.sv
module strobe_sync
    import sfifo_pkg::*;
#(
    parameter edge_sel_e SEL  = EDGE_RISE,
    parameter logic      IDLE = 1'b1
) (
    input  logic clk,
    input  logic clr_n,
    input  logic stb_i,
    output logic lvl_o,
    output logic edge_o
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d    = sync_q;
        sync_d.s1 = stb_i;
        sync_d.s2 = sync_q.s1;
        sync_d.s3 = sync_q.s2;
    end

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) sync_q <= '{s1: IDLE, s2: IDLE, s3: IDLE};
        else        sync_q <= sync_d;
    end

    // The flag level comes from the third stage. That stage updates on the
    // same edge as the pointers, so the flags never glitch.
    assign lvl_o = sync_q.s3;

    generate
        if (SEL == EDGE_RISE) begin : g_rise
            assign edge_o = sync_q.s2 & ~sync_q.s3;
        end else begin : g_fall
            assign edge_o = ~sync_q.s2 & sync_q.s3;
        end
    endgenerate
endmodule

// File: rtl/ring_ptr.sv
module ring_ptr #(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         clr_n,
    input  logic         adv,
    output logic [N-1:0] ptr_oh
);
    logic [N-1:0] ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (adv) ptr_d = {ptr_q[N-2:0], ptr_q[N-1]};
    end

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) ptr_q <= N'(1);
        else        ptr_q <= ptr_d;
    end

    assign ptr_oh = ptr_q;
endmodule

// File: rtl/strobe_fifo.sv
module strobe_fifo
    import sfifo_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             ld_stb,
    input  logic             ul_stb,
    input  logic             in_rdy_en,
    input  logic             out_rdy_en,
    input  logic             oe,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout,
    output logic [WIDTH-1:0] dout_oe,
    output logic             in_rdy,
    output logic             out_rdy
);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic             ld_lvl, ld_fall;
    logic             ul_lvl, ul_rise;
    logic             full, empty;
    logic             wr_fire, rd_fire;
    logic [DEPTH-1:0] wr_oh, rd_oh;
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic [WIDTH-1:0] rd_word;

    strobe_sync #(.SEL(EDGE_FALL), .IDLE(1'b0)) u_ld_sync (
        .clk(clk), .clr_n(clr_n), .stb_i(ld_stb), .lvl_o(ld_lvl), .edge_o(ld_fall)
    );

    strobe_sync #(.SEL(EDGE_RISE), .IDLE(1'b1)) u_ul_sync (
        .clk(clk), .clr_n(clr_n), .stb_i(ul_stb), .lvl_o(ul_lvl), .edge_o(ul_rise)
    );

    assign full    = (ctl_q.cnt == CW'(DEPTH));
    assign empty   = (ctl_q.cnt == '0);
    assign wr_fire = ld_fall & ~full;
    assign rd_fire = ul_rise & ~empty;

    ring_ptr #(.N(DEPTH)) u_wr_ptr (.clk(clk), .clr_n(clr_n), .adv(wr_fire), .ptr_oh(wr_oh));
    ring_ptr #(.N(DEPTH)) u_rd_ptr (.clk(clk), .clr_n(clr_n), .adv(rd_fire), .ptr_oh(rd_oh));

    always_comb begin
        ctl_d = ctl_q;
        case ({wr_fire, rd_fire})
            2'b10:   ctl_d.cnt = ctl_q.cnt + CW'(1);
            2'b01:   ctl_d.cnt = ctl_q.cnt - CW'(1);
            default: ctl_d.cnt = ctl_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    // One storage slot per ring position, written when its write-pointer bit is set.
    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_slot
            always_ff @(posedge clk) begin
                if (wr_fire && wr_oh[i]) mem_q[i] <= din;
            end
        end
    endgenerate

    // The read pointer is one-hot, so the read mux is an AND-OR tree.
    always_comb begin
        rd_word = '0;
        for (int i = 0; i < DEPTH; i++) begin
            rd_word = rd_word | (mem_q[i] & {WIDTH{rd_oh[i]}});
        end
    end

    assign dout    = rd_word;
    assign dout_oe = {WIDTH{oe}};
    assign in_rdy  = ~full & ~ld_lvl & in_rdy_en;
    assign out_rdy = ~empty & ul_lvl & out_rdy_en;
endmodule

// File: rtl/strobe_fifo_chk.sv
module strobe_fifo_chk #(
    parameter int DEPTH = 16,
    parameter int CW    = 5
) (
    input logic             clk,
    input logic             clr_n,
    input logic [CW-1:0]    cnt,
    input logic [DEPTH-1:0] wr_oh,
    input logic [DEPTH-1:0] rd_oh,
    input logic             ld_fall,
    input logic             ul_rise,
    input logic             in_rdy,
    input logic             out_rdy,
    input logic             in_rdy_en,
    input logic             out_rdy_en
);
    assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (!clr_n)
        cnt <= CW'(DEPTH));

    assert_wr_onehot_R9: assert property (@(posedge clk) disable iff (!clr_n)
        $countones(wr_oh) == 1);

    assert_rd_onehot_R9: assert property (@(posedge clk) disable iff (!clr_n)
        $countones(rd_oh) == 1);

    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!clr_n)
        (cnt == CW'(DEPTH) && ld_fall && !ul_rise) |=> ($stable(wr_oh) && cnt == CW'(DEPTH)));

    assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!clr_n)
        (cnt == '0 && ul_rise && !ld_fall) |=> ($stable(rd_oh) && cnt == '0));

    assert_in_rdy_gate_R6: assert property (@(posedge clk) disable iff (!clr_n)
        in_rdy |-> (cnt != CW'(DEPTH) && in_rdy_en));

    assert_out_rdy_gate_R7: assert property (@(posedge clk) disable iff (!clr_n)
        out_rdy |-> (cnt != '0 && out_rdy_en));

    assert_both_hold_R12: assert property (@(posedge clk) disable iff (!clr_n)
        (ld_fall && ul_rise && cnt != '0 && cnt != CW'(DEPTH))
        |=> (cnt == $past(cnt) && wr_oh != $past(wr_oh) && rd_oh != $past(rd_oh)));
endmodule

bind strobe_fifo strobe_fifo_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk(clk), .clr_n(clr_n), .cnt(ctl_q.cnt), .wr_oh(wr_oh), .rd_oh(rd_oh),
    .ld_fall(ld_fall), .ul_rise(ul_rise), .in_rdy(in_rdy), .out_rdy(out_rdy),
    .in_rdy_en(in_rdy_en), .out_rdy_en(out_rdy_en)
);

// File: tb/strobe_fifo_test.sv
`timescale 1ns/1ps
module strobe_fifo_test;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         clr_n, ld_stb, ul_stb, in_rdy_en, out_rdy_en, oe;
    logic [W-1:0] din, dout, dout_oe;
    logic         in_rdy, out_rdy;
    int           checks = 0;
    int           fails  = 0;
    bit           done   = 0;

    always #2.5 clk = ~clk;

    strobe_fifo uut (
        .clk(clk), .clr_n(clr_n), .ld_stb(ld_stb), .ul_stb(ul_stb),
        .in_rdy_en(in_rdy_en), .out_rdy_en(out_rdy_en), .oe(oe), .din(din),
        .dout(dout), .dout_oe(dout_oe), .in_rdy(in_rdy), .out_rdy(out_rdy)
    );

    // op: 0 idle, 1 load, 2 unload, 3 load and unload together
    typedef struct packed {
        logic [1:0]   op;
        logic [W-1:0] d;
        logic [W-1:0] q;
        logic         ir;
        logic         orr;
        logic         qchk;
    } vec_t;

    localparam vec_t VECS [11] = '{
        '{2'd0, 4'h0, 4'h0, 1'b1, 1'b0, 1'b0},
        '{2'd1, 4'h5, 4'h5, 1'b1, 1'b1, 1'b1},  // R11 first word falls through
        '{2'd1, 4'hA, 4'h5, 1'b1, 1'b1, 1'b1},
        '{2'd1, 4'h3, 4'h5, 1'b1, 1'b1, 1'b1},
        '{2'd2, 4'h0, 4'hA, 1'b1, 1'b1, 1'b1},
        '{2'd3, 4'hC, 4'h3, 1'b1, 1'b1, 1'b1},  // R12
        '{2'd2, 4'h0, 4'hC, 1'b1, 1'b1, 1'b1},
        '{2'd2, 4'h0, 4'h0, 1'b1, 1'b0, 1'b0},
        '{2'd2, 4'h0, 4'h0, 1'b1, 1'b0, 1'b0},  // R5 unload while empty
        '{2'd1, 4'h9, 4'h9, 1'b1, 1'b1, 1'b1},  // R5 read pointer did not move
        '{2'd2, 4'h0, 4'h0, 1'b1, 1'b0, 1'b0}
    };

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic pulse(input bit do_ld, input bit do_ul, input logic [W-1:0] d);
        @(negedge clk);
        din = d;
        if (do_ld) ld_stb = 1'b1;
        if (do_ul) ul_stb = 1'b0;
        repeat (4) @(negedge clk);
        ld_stb = 1'b0;
        ul_stb = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        clr_n = 1'b0; ld_stb = 1'b0; ul_stb = 1'b1;
        in_rdy_en = 1'b1; out_rdy_en = 1'b1; oe = 1'b1; din = '0;
        repeat (3) @(negedge clk);
        clr_n = 1'b1;
        @(negedge clk);
        chk("R8 in_rdy after clear", W'(in_rdy), W'(1));
        chk("R8 out_rdy after clear", W'(out_rdy), W'(0));

        // Table walk.
        for (int i = 0; i < 11; i++) begin
            case (VECS[i].op)
                2'd0: repeat (4) @(negedge clk);
                2'd1: pulse(1'b1, 1'b0, VECS[i].d);
                2'd2: pulse(1'b0, 1'b1, VECS[i].d);
                default: pulse(1'b1, 1'b1, VECS[i].d);
            endcase
            chk(VECS[i].op == 2'd3 ? "R12 in_rdy" : "R6 in_rdy", W'(in_rdy), W'(VECS[i].ir));
            chk(VECS[i].op == 2'd2 ? "R3 out_rdy" : "R7 out_rdy", W'(out_rdy), W'(VECS[i].orr));
            if (VECS[i].qchk)
                chk(VECS[i].op == 2'd3 ? "R12 dout" : "R1 dout", dout, VECS[i].q);
        end

        // Load latency and strobe masking of in_rdy.
        @(negedge clk);
        din = 4'h1; ld_stb = 1'b1;
        repeat (3) @(negedge clk);
        chk("R6 in_rdy masked by load strobe", W'(in_rdy), W'(0));
        @(negedge clk);
        ld_stb = 1'b0;
        repeat (2) @(negedge clk);
        chk("R2 out_rdy before third edge", W'(out_rdy), W'(0));
        @(negedge clk);
        chk("R2 out_rdy at third edge", W'(out_rdy), W'(1));
        chk("R11 dout at third edge", dout, 4'h1);
        @(negedge clk);
        pulse(1'b1, 1'b0, 4'h2);

        // Unload latency and strobe masking of out_rdy.
        @(negedge clk);
        ul_stb = 1'b0;
        repeat (4) @(negedge clk);
        chk("R7 out_rdy masked by unload strobe", W'(out_rdy), W'(0));
        ul_stb = 1'b1;
        repeat (2) @(negedge clk);
        chk("R3 dout before third edge", dout, 4'h1);
        @(negedge clk);
        chk("R3 dout at third edge", dout, 4'h2);
        chk("R3 out_rdy at third edge", W'(out_rdy), W'(1));
        @(negedge clk);

        // Enables and output enable.
        in_rdy_en = 1'b0;
        @(negedge clk);
        chk("R6 in_rdy_en low", W'(in_rdy), W'(0));
        in_rdy_en = 1'b1; out_rdy_en = 1'b0;
        @(negedge clk);
        chk("R7 out_rdy_en low", W'(out_rdy), W'(0));
        out_rdy_en = 1'b1; oe = 1'b0;
        @(negedge clk);
        chk("R10 drive enable off", dout_oe, 4'h0);
        chk("R10 in_rdy with oe low", W'(in_rdy), W'(1));
        chk("R10 out_rdy with oe low", W'(out_rdy), W'(1));
        oe = 1'b1;
        @(negedge clk);
        chk("R10 drive enable on", dout_oe, 4'hF);
        chk("R10 noninverted data", dout, 4'h2);
        pulse(1'b0, 1'b1, 4'h0);
        chk("R5 empty again", W'(out_rdy), W'(0));

        // Fill to capacity, the pointers wrap on the way.
        for (int i = 0; i < 16; i++) begin
            pulse(1'b1, 1'b0, W'(i));
            chk("R4 in_rdy while filling", W'(in_rdy), (i < 15) ? W'(1) : W'(0));
        end
        pulse(1'b1, 1'b0, 4'hF);
        chk("R4 in_rdy stays low when full", W'(in_rdy), W'(0));
        chk("R11 oldest word when full", dout, 4'h0);
        for (int i = 0; i < 16; i++) begin
            chk("R9 order across wrap", dout, W'(i));
            pulse(1'b0, 1'b1, 4'h0);
        end
        chk("R4 load while full ignored", W'(out_rdy), W'(0));

        // Clear with data present.
        pulse(1'b1, 1'b0, 4'h4);
        pulse(1'b1, 1'b0, 4'h8);
        @(negedge clk);
        clr_n = 1'b0;
        repeat (2) @(negedge clk);
        clr_n = 1'b1;
        @(negedge clk);
        chk("R8 out_rdy after clear", W'(out_rdy), W'(0));
        chk("R8 in_rdy after clear", W'(in_rdy), W'(1));
        pulse(1'b1, 1'b0, 4'h6);
        chk("R8 pointers restart", dout, 4'h6);
        chk("R8 out_rdy after reload", W'(out_rdy), W'(1));

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule